// File: doc/BRIEF.md
# Ping-Pong Circular Sample Stream Engine

This block moves 16-bit audio samples between system memory and one fixed peripheral data port. It serves playback, where samples go from memory to the peripheral, and recording, where samples go from the peripheral to memory. The peripheral asks for each sample with a level request. For each request the engine makes exactly one halfword access on its memory port. When that access completes, it acknowledges the peripheral.

Memory is split into two buffers of equal length at independent base addresses. The engine streams through buffer 0, then buffer 1, then buffer 0 again, without end. The memory address advances by one halfword per sample, and the peripheral side never moves. When the last sample of a buffer completes, the engine does three things:

- it switches to the other buffer;
- it flips a current-buffer indication;
- if interrupts are enabled, it sets a sticky completion flag and records which buffer finished.

Software refills the idle buffer while the other one streams. It clears the flag with a one-cycle clear pulse.

The configuration is captured when the stream starts and is frozen while the stream reports itself active. A length of zero keeps the stream from starting. Starting a stream clears any pending flag.

Top module: `dbuf_sample_dma`

## Requirements
- R1: After reset, `active`, `mem_req`, `per_ack`, `tc_flag`, `irq` and `cur_tgt` are all 0.
- R2: While `cfg_len` is 0, raising `en` does not start the stream: `active` stays 0 and no memory access is issued, even with `per_req` high.
- R3: When `cfg_dir`=0 (playback), each peripheral request causes one memory read (`mem_we`=0). The halfword returned with `mem_gnt` appears on `per_wdata` while `per_ack` is high.
- R4: When `cfg_dir`=1 (recording), `per_rdata` sampled at the request is written to memory with `mem_we`=1 and `mem_wdata` equal to that sample.
- R5: Sample i of a buffer is accessed at that buffer's base plus 2*i, so the address rises by 2 per sample. Buffer 0 (`cfg_base0`) is used first, and buffers alternate at each buffer end.
- R6: `cur_tgt` is 0 when a stream starts and toggles at the completion of each buffer's last sample.
- R7: With `cfg_tc_ie`=1, completing a buffer sets `tc_flag`. `irq` is high while the flag is set. `tc_buf` gives the index (0 or 1) of the buffer that just finished.
- R8: `tc_flag` stays set until a cycle with `flag_clr`=1 clears it. A completion in the same cycle as a clear leaves the flag set.
- R9: With `cfg_tc_ie`=0, buffer completions never set `tc_flag` or `irq`.
- R10: Changes on `cfg_base0`, `cfg_base1`, `cfg_len`, `cfg_dir` and `cfg_tc_ie` while `active`=1 have no effect on the running stream.
- R11: Dropping `en` stops the stream after any access in progress, and `active` falls. A later start begins again at buffer 0, sample 0, with `cur_tgt`=0 and `tc_flag` cleared.
- R12: `mem_req` is raised only in response to a peripheral request. Once raised, it stays high with a stable `mem_addr` until `mem_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Stream enable |
| cfg_dir | input | 1 | 0 = memory to peripheral, 1 = peripheral to memory |
| cfg_tc_ie | input | 1 | Completion interrupt enable |
| cfg_base0 | input | AW | Byte base address of buffer 0 |
| cfg_base1 | input | AW | Byte base address of buffer 1 |
| cfg_len | input | CW | Buffer length in samples |
| flag_clr | input | 1 | Write-1 clear of the completion flag |
| active | output | 1 | Stream is running; configuration is frozen |
| cur_tgt | output | 1 | Buffer currently being streamed |
| tc_flag | output | 1 | Sticky buffer-completion flag |
| tc_buf | output | 1 | Buffer that completed last |
| irq | output | 1 | Interrupt request |
| per_req | input | 1 | Peripheral sample request (level, held until ack) |
| per_ack | output | 1 | One-cycle sample acknowledge |
| per_rdata | input | 16 | Sample from peripheral (recording) |
| per_wdata | output | 16 | Sample to peripheral (playback) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when 1 |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_gnt | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 16 | Memory read data, valid with `mem_gnt` |

## Verification
The bench runs playback across two full buffer turns.

- A design that wrapped one sample early or late would show a wrong address at a buffer seam. A design that reused the same base twice would show the wrong base there.
- Right after each seam the bench checks `cur_tgt`, `tc_flag` and `tc_buf`. A design that reported the new buffer instead of the finished one would be caught there.
- The bench rewrites the configuration mid-stream. A design that read the live inputs instead of latched copies would change buffer length or direction.
- The bench also covers a zero length with a pending request, disable and restart with a stale flag, and recording with interrupts off. These catch a block that starts on an empty buffer, resumes mid-buffer, or sets the flag without the enable.

// File: rtl/dma_pkg.sv
// Shared types for the ping-pong sample stream engine.
package dma_pkg;
    localparam int SAMPLE_W  = 16;   // halfword sample width
    localparam int ADDR_STEP = 2;    // bytes per sample

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // stream off, configuration may change
        ST_WAIT = 2'd1,   // running, waiting for a peripheral request
        ST_MEM  = 2'd2,   // memory access outstanding
        ST_ACK  = 2'd3    // acknowledging the peripheral
    } dma_state_t;
endpackage

// File: rtl/dma_addr_gen.sv
// Address generator: tracks the sample index inside the active buffer and
// which of the two buffers is active. Assumes base/len are held stable by
// the caller for the whole stream and len is nonzero while adv can occur.
module dma_addr_gen #(
    parameter int AW = 16,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          adv,
    input  logic [AW-1:0] base0,
    input  logic [AW-1:0] base1,
    input  logic [CW-1:0] len,
    output logic [AW-1:0] addr,
    output logic          tgt,
    output logic          wrap
);
    logic [CW-1:0] idx_q;
    logic          tgt_q;

    // Index and buffer select: restart at buffer 0, step per beat, swap at end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            tgt_q <= 1'b0;
        end else if (start) begin
            idx_q <= '0;
            tgt_q <= 1'b0;
        end else if (adv) begin
            if (wrap) begin
                idx_q <= '0;
                tgt_q <= ~tgt_q;
            end else begin
                idx_q <= idx_q + CW'(1);
            end
        end
    end

    // Current byte address and last-sample detect.
    always_comb begin
        addr = (tgt_q ? base1 : base0) + (AW'(idx_q) * AW'(dma_pkg::ADDR_STEP));
        wrap = (idx_q == (len - CW'(1)));
    end

    assign tgt = tgt_q;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wrap && !start) |=> (addr == $past(addr) + AW'(2)));   // R5
    AST_WRAP_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && wrap && !start) |=> (tgt != $past(tgt)) && (addr == (tgt ? base1 : base0)) && (idx_q == '0));   // R6
endmodule

// File: rtl/dma_tc_flag.sv
// Completion flag: sticky, set on buffer end when enabled, cleared by a
// write-1 pulse or by a stream start. Also records which buffer finished.
module dma_tc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    input  logic done_buf,
    input  logic ie,
    input  logic clr,
    output logic flag,
    output logic buf_id
);
    // Flag register: set has priority over the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           flag <= 1'b0;
        else if (start)       flag <= 1'b0;
        else if (done && ie)  flag <= 1'b1;
        else if (clr)         flag <= 1'b0;
    end

    // Finished-buffer identity, captured at each completion.
    always_ff @(posedge clk) begin
        if (!rst_n)    buf_id <= 1'b0;
        else if (done) buf_id <= done_buf;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr && !start) |=> flag);   // R8
    AST_FLAG_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !ie) |=> !flag);   // R9
endmodule

// File: rtl/dbuf_sample_dma.sv
// Ping-pong circular sample stream engine. Moves one 16-bit sample per
// peripheral request between a fixed peripheral port and two alternating
// memory buffers. Assumes per_req is a level held until per_ack, and the
// memory port returns mem_gnt (with mem_rdata for reads) once per request.
module dbuf_sample_dma #(
    parameter int AW = 16,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cfg_dir,
    input  logic          cfg_tc_ie,
    input  logic [AW-1:0] cfg_base0,
    input  logic [AW-1:0] cfg_base1,
    input  logic [CW-1:0] cfg_len,
    input  logic          flag_clr,
    output logic          active,
    output logic          cur_tgt,
    output logic          tc_flag,
    output logic          tc_buf,
    output logic          irq,
    input  logic          per_req,
    output logic          per_ack,
    input  logic [15:0]   per_rdata,
    output logic [15:0]   per_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic          mem_gnt,
    input  logic [15:0]   mem_rdata
);
    import dma_pkg::*;

    dma_state_t            state_q;
    logic                  dir_q, ie_q;
    logic [AW-1:0]         b0_q, b1_q;
    logic [CW-1:0]         len_q;
    logic [SAMPLE_W-1:0]   rec_q, play_q;
    logic                  start, adv, wrap;

    assign start = (state_q == ST_IDLE) && en && (cfg_len != '0);
    assign adv   = (state_q == ST_MEM) && mem_gnt;

    // Beat sequencer: wait for request, one memory access, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start)         state_q <= ST_WAIT;
                ST_WAIT: if (!en)           state_q <= ST_IDLE;
                         else if (per_req)  state_q <= ST_MEM;
                ST_MEM:  if (mem_gnt)       state_q <= ST_ACK;
                ST_ACK:  state_q <= en ? ST_WAIT : ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Configuration snapshot, taken only when the stream starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            ie_q  <= 1'b0;
            b0_q  <= '0;
            b1_q  <= '0;
            len_q <= '0;
        end else if (start) begin
            dir_q <= cfg_dir;
            ie_q  <= cfg_tc_ie;
            b0_q  <= cfg_base0;
            b1_q  <= cfg_base1;
            len_q <= cfg_len;
        end
    end

    // Data holding: recorded sample at request, played sample at grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q  <= '0;
            play_q <= '0;
        end else begin
            if (state_q == ST_WAIT && en && per_req) rec_q <= per_rdata;
            if (adv && !dir_q)                        play_q <= mem_rdata;
        end
    end

    dma_addr_gen #(.AW(AW), .CW(CW)) u_addr (
        .clk(clk), .rst_n(rst_n), .start(start), .adv(adv),
        .base0(b0_q), .base1(b1_q), .len(len_q),
        .addr(mem_addr), .tgt(cur_tgt), .wrap(wrap)
    );

    dma_tc_flag u_flag (
        .clk(clk), .rst_n(rst_n), .start(start),
        .done(adv && wrap), .done_buf(cur_tgt), .ie(ie_q),
        .clr(flag_clr), .flag(tc_flag), .buf_id(tc_buf)
    );

    assign active    = (state_q != ST_IDLE);
    assign mem_req   = (state_q == ST_MEM);
    assign mem_we    = dir_q;
    assign mem_wdata = rec_q;
    assign per_ack   = (state_q == ST_ACK);
    assign per_wdata = play_q;
    assign irq       = tc_flag && ie_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));   // R12
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && cfg_len == '0) |=> !active);   // R2
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> ($stable(len_q) && $stable(b0_q) && $stable(b1_q) && $stable(dir_q)));   // R10
    AST_ACK_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_ack) |-> $past(mem_req && mem_gnt));   // R3
    AST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (per_ack && !en) |=> !active);   // R11
endmodule

// File: tb/sim_dbuf_sample_dma.sv
`timescale 1ns/1ps
module sim_dbuf_sample_dma;
    localparam int AW = 16;
    localparam int CW = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 0, cfg_dir = 0, cfg_tc_ie = 0, flag_clr = 0;
    logic [AW-1:0] cfg_base0 = '0, cfg_base1 = '0;
    logic [CW-1:0] cfg_len = '0;
    logic active, cur_tgt, tc_flag, tc_buf, irq;
    logic per_req = 0, per_ack;
    logic [15:0] per_rdata = '0, per_wdata;
    logic mem_req, mem_we, mem_gnt;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    int nchk = 0, nerr = 0;
    logic [15:0] wmem [0:255];
    logic [AW-1:0] last_addr;
    logic last_we;
    int req_cycles;

    always #2 clk = ~clk;

    dbuf_sample_dma #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_dir(cfg_dir), .cfg_tc_ie(cfg_tc_ie),
        .cfg_base0(cfg_base0), .cfg_base1(cfg_base1), .cfg_len(cfg_len),
        .flag_clr(flag_clr), .active(active), .cur_tgt(cur_tgt), .tc_flag(tc_flag),
        .tc_buf(tc_buf), .irq(irq), .per_req(per_req), .per_ack(per_ack),
        .per_rdata(per_rdata), .per_wdata(per_wdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    // Memory model: grant one cycle after a request, read data = addr ^ 5A5A.
    assign mem_rdata = mem_addr ^ 16'h5A5A;
    always @(posedge clk) begin
        if (!rst_n) mem_gnt <= 1'b0;
        else        mem_gnt <= mem_req && !mem_gnt;
        if (mem_req && mem_gnt) begin
            last_addr <= mem_addr;
            last_we   <= mem_we;
            if (mem_we) wmem[mem_addr[8:1]] <= mem_wdata;
        end
        if (mem_req) req_cycles <= req_cycles + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sample(input logic [15:0] pdata, output logic [15:0] got);
        bit seen = 0;
        @(negedge clk);
        per_req = 1'b1;
        per_rdata = pdata;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (per_ack) begin seen = 1; break; end
        end
        check("R3 ack seen", 32'(seen), 32'd1);
        got = per_wdata;
        per_req = 1'b0;
    endtask

    task automatic stop_stream();
        @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 active", 32'(active), 0);
        check("R1 mem_req", 32'(mem_req), 0);
        check("R1 per_ack", 32'(per_ack), 0);
        check("R1 tc_flag", 32'(tc_flag), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 cur_tgt", 32'(cur_tgt), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_zero_len();
        @(negedge clk);
        cfg_len = '0; cfg_base0 = 16'h100; en = 1'b1; per_req = 1'b1;
        req_cycles = 0;
        repeat (6) @(negedge clk);
        check("R2 active with zero length", 32'(active), 0);
        check("R12 no mem access when idle", 32'(req_cycles), 0);
        per_req = 1'b0;
        stop_stream();
    endtask

    task automatic t_playback();
        logic [15:0] got;
        logic [AW-1:0] exp_a;
        @(negedge clk);
        cfg_base0 = 16'h100; cfg_base1 = 16'h200; cfg_len = 12'd3;
        cfg_dir = 1'b0; cfg_tc_ie = 1'b1; en = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 cur_tgt at start", 32'(cur_tgt), 0);
        for (int i = 0; i < 7; i++) begin
            exp_a = (((i / 3) % 2) != 0 ? 16'h200 : 16'h100) + 16'(2 * (i % 3));
            sample(16'h0, got);
            check("R5 address", 32'(last_addr), 32'(exp_a));
            check("R3 read", 32'(last_we), 0);
            check("R3 per_wdata", 32'(got), 32'(exp_a ^ 16'h5A5A));
            if (i == 2) begin
                check("R6 toggle after buf0", 32'(cur_tgt), 1);
                check("R7 flag set", 32'(tc_flag), 1);
                check("R7 irq", 32'(irq), 1);
                check("R7 tc_buf 0", 32'(tc_buf), 0);
                flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
                check("R8 clear", 32'(tc_flag), 0);
            end
            if (i == 5) begin
                check("R6 toggle after buf1", 32'(cur_tgt), 0);
                check("R7 flag set again", 32'(tc_flag), 1);
                check("R7 tc_buf 1", 32'(tc_buf), 1);
                repeat (5) @(negedge clk);
                check("R8 flag sticky", 32'(tc_flag), 1);
                flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
                check("R8 clear again", 32'(tc_flag), 0);
                check("R7 irq low", 32'(irq), 0);
            end
        end
        stop_stream();
    endtask

    task automatic t_record();
        logic [15:0] got;
        @(negedge clk);
        cfg_base0 = 16'h40; cfg_base1 = 16'h80; cfg_len = 12'd2;
        cfg_dir = 1'b1; cfg_tc_ie = 1'b0; en = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            sample(16'h1000 + 16'(i), got);
            check("R4 write", 32'(last_we), 1);
        end
        check("R4 data b0[0]", 32'(wmem[8'h20]), 32'h1000);
        check("R4 data b0[1]", 32'(wmem[8'h21]), 32'h1001);
        check("R4 data b1[0]", 32'(wmem[8'h40]), 32'h1002);
        check("R4 data b1[1]", 32'(wmem[8'h41]), 32'h1003);
        check("R9 no flag", 32'(tc_flag), 0);
        check("R9 no irq", 32'(irq), 0);
        check("R6 back to buf0", 32'(cur_tgt), 0);
        stop_stream();
    endtask

    task automatic t_frozen_and_restart();
        logic [15:0] got;
        @(negedge clk);
        cfg_base0 = 16'h10; cfg_base1 = 16'h20; cfg_len = 12'd2;
        cfg_dir = 1'b0; cfg_tc_ie = 1'b1; en = 1'b1;
        repeat (2) @(negedge clk);
        sample(16'h0, got);
        cfg_base1 = 16'h30; cfg_len = 12'd4; cfg_dir = 1'b1; cfg_tc_ie = 1'b0;
        sample(16'h0, got);
        check("R10 length frozen", 32'(cur_tgt), 1);
        check("R10 ie frozen", 32'(tc_flag), 1);
        sample(16'h0, got);
        check("R10 base1 frozen", 32'(last_addr), 32'h20);
        check("R10 dir frozen", 32'(last_we), 0);
        // R11: stop, then restart with a stale flag
        @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 inactive", 32'(active), 0);
        check("R11 no mem_req", 32'(mem_req), 0);
        cfg_base1 = 16'h20; cfg_len = 12'd2; cfg_dir = 1'b0;
        en = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 flag cleared on start", 32'(tc_flag), 0);
        check("R11 cur_tgt reset", 32'(cur_tgt), 0);
        sample(16'h0, got);
        check("R11 restart at base0", 32'(last_addr), 32'h10);
        stop_stream();
    endtask

    initial begin
        #(4 * 100000);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        req_cycles = 0;
        t_reset();
        t_zero_len();
        t_playback();
        t_record();
        t_frozen_and_restart();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule